// File: doc/BRIEF.md
# Radio synthesizer programming sequencer

This block steps a frame serializer through the scripted programming sequences that a handheld UHF transceiver needs for its frequency synthesizer. After reset it keeps the serial lines parked for a long, configurable hold. It then runs an initialisation script that loads the reference divider twice, selects receive mode and tunes the receive channel twice. After that it waits in an idle state. When push-to-talk goes high it runs the transmit script: transmit configuration, the transmit frequency, then a second transmit configuration word sent twice. When push-to-talk goes low it runs the return script: receive configuration, then the receive frequency. Every frame is followed by its own pause, counted in microseconds.

The frequency frame is built from a half-divide-ratio input. The upper bits become the programmable counter and the low five bits become the swallow counter, followed by a 3-bit register code. The reference frame carries a fixed reference divider value. The serial wire timing is the serializer's job. The sequencer only hands over one right-justified frame word with its bit length, using a start/ready/done handshake.

States: `ST_HOLD` (parked lines, hold timer), `ST_LAUNCH` (offer a frame once the serializer is ready), `ST_WAIT` (wait for the done pulse), `ST_PAUSE` (post-frame pause), `ST_IDLE` (compare push-to-talk with the current mode). The transitions are:
- reset goes to `ST_HOLD`;
- `ST_HOLD` goes to `ST_LAUNCH` when the hold expires;
- `ST_LAUNCH` goes to `ST_WAIT` when the start pulse is issued;
- `ST_WAIT` goes to `ST_PAUSE` on done when the step has a pause, and otherwise to `ST_LAUNCH` or `ST_IDLE`;
- `ST_PAUSE` goes to `ST_LAUNCH` (next step) or `ST_IDLE` (last step) when the pause expires;
- `ST_IDLE` goes to `ST_LAUNCH` (first step of the transmit or return script) on a push-to-talk mismatch.

Top module: `uhf_synth_sequencer`

## Requirements
- R1: Following reset release, `park_o` stays high and no frame start occurs for exactly HOLD_US*CYC_PER_US clock cycles; `park_o` never rises again without a reset.
- R2: The initialisation script sends, in order: reference frame (pause 50 us), reference frame (pause 300 us), receive configuration 0x02E805 (pause 100 us), receive frequency frame (pause 800 us), receive configuration (pause 100 us), receive frequency frame (no pause).
- R3: The reference frame is 17 bits long: a 2-bit prefix 01, the 12-bit reference count (default 820), then the code 111. With defaults it equals 0x099A7.
- R4: The frequency frame is 19 bits long: bits 18:8 hold the half ratio divided by 32, bits 7:3 hold the half ratio modulo 32, and bits 2:0 hold the code 001. For example, 36149 gives 0x469A9, 65535 gives 0x7FFF9 and 0 gives 0x00001.
- R5: A rise of push-to-talk runs the transmit script: transmit configuration 0x02E005, transmit frequency frame, then 0x02E205 twice, each followed by 100 us.
- R6: A fall of push-to-talk runs the return script: 0x02E805 (pause 100 us), then the receive frequency frame with no pause. Configuration frames are 18 bits long.
- R7: A push-to-talk change is acted on only after the running script's last pause ends. If the level differs from the current mode at that point, the opposite script starts two cycles after the pause expires (pause*CYC_PER_US+2 cycles after the last done pulse).
- R8: A push-to-talk excursion that returns to the current mode's level before the script ends starts no further frame.
- R9: Within a script, the next frame start comes exactly pause*CYC_PER_US+1 cycles after the done pulse of the previous frame.
- R10: `frm_start_o` is a single-cycle pulse asserted only while `ser_ready_i` is high, once per frame. Each start is matched by one done before the next start.
- R11: A reset during a script returns the block to the hold and reruns the initialisation script in receive mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptt_i | input | 1 | Push-to-talk level, synchronous to clk |
| tx_half_i | input | PROG_W+SWAL_W | Transmit half divide ratio |
| rx_half_i | input | PROG_W+SWAL_W | Receive half divide ratio |
| ser_ready_i | input | 1 | Serializer can accept a frame |
| ser_done_i | input | 1 | Serializer finished a frame (one-cycle pulse) |
| frm_start_o | output | 1 | Frame start pulse |
| frm_data_o | output | PROG_W+SWAL_W+3 | Frame word, right-justified |
| frm_len_o | output | 5 | Frame length in bits |
| park_o | output | 1 | Hold serial lines parked (clock and enable low, data high) |

## Verification
Two functions of this block can meet in one cycle: a push-to-talk edge and the end of a running script's final pause. The bench drops push-to-talk in the middle of a transmit script, so the return script must start directly after the pause, with the gap measured to the exact cycle. It also flips push-to-talk away and back during another transmit script, then watches the frame outputs for a long window to confirm that nothing extra is launched.

// File: rtl/synth_seq_pkg.sv
package synth_seq_pkg;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_LAUNCH,
        ST_WAIT,
        ST_PAUSE,
        ST_IDLE
    } seq_state_e;

    typedef enum logic [1:0] {
        SCR_INIT,
        SCR_TX,
        SCR_RX
    } script_e;

    typedef enum logic [2:0] {
        FK_REF,
        FK_CFG_RX,
        FK_CFG_TX,
        FK_CFG_TX2,
        FK_FRQ_RX,
        FK_FRQ_TX
    } frame_kind_e;

    localparam int PAUSE_W = 10;

    typedef struct packed {
        frame_kind_e          kind;
        logic [PAUSE_W-1:0]   pause_us;
        logic                 last;
    } step_t;

    localparam int IDX_W        = 3;
    localparam int PAUSE_REF_A  = 50;
    localparam int PAUSE_REF_B  = 300;
    localparam int PAUSE_STEP   = 100;
    localparam int PAUSE_SETTLE = 800;
    localparam int PAUSE_MAX    = PAUSE_SETTLE;

    localparam int          CFG_W       = 18;
    localparam logic [17:0] CFG_RX_WORD  = 18'h2E805;
    localparam logic [17:0] CFG_TX_WORD  = 18'h2E005;
    localparam logic [17:0] CFG_TX2_WORD = 18'h2E205;

endpackage

// File: rtl/synth_us_ticker.sv
module synth_us_ticker #(
    parameter int CYC_PER_US = 10,
    parameter int US_W       = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    output logic            tick_o,
    output logic [US_W-1:0] us_o
);
    localparam int CNT_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;

    logic [CNT_W-1:0] cnt_q;

    assign tick_o = (cnt_q == CNT_W'(CYC_PER_US - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            us_o  <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
            us_o  <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
            us_o  <= us_o + 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/synth_step_rom.sv
module synth_step_rom
    import synth_seq_pkg::*;
(
    input  script_e          scr_i,
    input  logic [IDX_W-1:0] idx_i,
    output step_t            step_o
);
    function automatic step_t mk(frame_kind_e k, int p, logic l);
        step_t s;
        s.kind     = k;
        s.pause_us = PAUSE_W'(p);
        s.last     = l;
        return s;
    endfunction

    always_comb begin
        step_o = mk(FK_REF, 0, 1'b1);
        unique case (scr_i)
            SCR_INIT: begin
                unique case (idx_i)
                    3'd0:    step_o = mk(FK_REF,    PAUSE_REF_A,  1'b0);
                    3'd1:    step_o = mk(FK_REF,    PAUSE_REF_B,  1'b0);
                    3'd2:    step_o = mk(FK_CFG_RX, PAUSE_STEP,   1'b0);
                    3'd3:    step_o = mk(FK_FRQ_RX, PAUSE_SETTLE, 1'b0);
                    3'd4:    step_o = mk(FK_CFG_RX, PAUSE_STEP,   1'b0);
                    default: step_o = mk(FK_FRQ_RX, 0,            1'b1);
                endcase
            end
            SCR_TX: begin
                unique case (idx_i)
                    3'd0:    step_o = mk(FK_CFG_TX,  PAUSE_STEP, 1'b0);
                    3'd1:    step_o = mk(FK_FRQ_TX,  PAUSE_STEP, 1'b0);
                    3'd2:    step_o = mk(FK_CFG_TX2, PAUSE_STEP, 1'b0);
                    default: step_o = mk(FK_CFG_TX2, PAUSE_STEP, 1'b1);
                endcase
            end
            SCR_RX: begin
                unique case (idx_i)
                    3'd0:    step_o = mk(FK_CFG_RX, PAUSE_STEP, 1'b0);
                    default: step_o = mk(FK_FRQ_RX, 0,          1'b1);
                endcase
            end
            default: step_o = mk(FK_REF, 0, 1'b1);
        endcase
    end
endmodule

// File: rtl/synth_frame_builder.sv
module synth_frame_builder
    import synth_seq_pkg::*;
#(
    parameter int PROG_W  = 11,
    parameter int SWAL_W  = 5,
    parameter int REF_W   = 12,
    parameter int REF_CNT = 820,
    parameter int FRAME_W = PROG_W + SWAL_W + 3,
    parameter int LEN_W   = 5
) (
    input  frame_kind_e                kind_i,
    input  logic [PROG_W+SWAL_W-1:0]   tx_half_i,
    input  logic [PROG_W+SWAL_W-1:0]   rx_half_i,
    output logic [FRAME_W-1:0]         data_o,
    output logic [LEN_W-1:0]           len_o
);
    localparam int HALF_W = PROG_W + SWAL_W;
    localparam int REF_LEN = REF_W + 5;

    logic [HALF_W-1:0] half;
    logic [PROG_W-1:0] prog_cnt;
    logic [SWAL_W-1:0] swal_cnt;

    always_comb begin
        half     = (kind_i == FK_FRQ_TX) ? tx_half_i : rx_half_i;
        prog_cnt = half[HALF_W-1:SWAL_W];
        swal_cnt = half[SWAL_W-1:0];
        unique case (kind_i)
            FK_REF: begin
                data_o = FRAME_W'({2'b01, REF_W'(REF_CNT), 3'b111});
                len_o  = LEN_W'(REF_LEN);
            end
            FK_CFG_RX: begin
                data_o = FRAME_W'(CFG_RX_WORD);
                len_o  = LEN_W'(CFG_W);
            end
            FK_CFG_TX: begin
                data_o = FRAME_W'(CFG_TX_WORD);
                len_o  = LEN_W'(CFG_W);
            end
            FK_CFG_TX2: begin
                data_o = FRAME_W'(CFG_TX2_WORD);
                len_o  = LEN_W'(CFG_W);
            end
            default: begin
                data_o = {prog_cnt, swal_cnt, 3'b001};
                len_o  = LEN_W'(FRAME_W);
            end
        endcase
    end
endmodule

// File: rtl/uhf_synth_sequencer.sv
module uhf_synth_sequencer
    import synth_seq_pkg::*;
#(
    parameter int CYC_PER_US = 10,
    parameter int HOLD_US    = 1500000,
    parameter int PROG_W     = 11,
    parameter int SWAL_W     = 5,
    parameter int REF_W      = 12,
    parameter int REF_CNT    = 820
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              ptt_i,
    input  logic [PROG_W+SWAL_W-1:0]          tx_half_i,
    input  logic [PROG_W+SWAL_W-1:0]          rx_half_i,
    input  logic                              ser_ready_i,
    input  logic                              ser_done_i,
    output logic                              frm_start_o,
    output logic [PROG_W+SWAL_W+2:0]          frm_data_o,
    output logic [4:0]                        frm_len_o,
    output logic                              park_o
);
    localparam int FRAME_W = PROG_W + SWAL_W + 3;
    localparam int US_MAX  = (HOLD_US > PAUSE_MAX) ? HOLD_US : PAUSE_MAX;
    localparam int US_W    = $clog2(US_MAX + 1);

    seq_state_e       state_q, state_d;
    script_e          scr_q, scr_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             txm_q, txm_d;
    logic             tick, tick_clr;
    logic [US_W-1:0]  us_cnt;
    step_t            step;
    logic             pause_end, hold_end;

    synth_us_ticker #(.CYC_PER_US(CYC_PER_US), .US_W(US_W)) u_ticker (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (tick_clr),
        .tick_o (tick),
        .us_o   (us_cnt)
    );

    synth_step_rom u_steps (
        .scr_i  (scr_q),
        .idx_i  (idx_q),
        .step_o (step)
    );

    synth_frame_builder #(
        .PROG_W (PROG_W), .SWAL_W (SWAL_W), .REF_W (REF_W),
        .REF_CNT(REF_CNT), .FRAME_W(FRAME_W), .LEN_W(5)
    ) u_frame (
        .kind_i    (step.kind),
        .tx_half_i (tx_half_i),
        .rx_half_i (rx_half_i),
        .data_o    (frm_data_o),
        .len_o     (frm_len_o)
    );

    assign hold_end  = tick && (us_cnt == US_W'(HOLD_US - 1));
    assign pause_end = tick && (us_cnt == US_W'(step.pause_us - 1'b1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            scr_q   <= SCR_INIT;
            idx_q   <= '0;
            txm_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            scr_q   <= scr_d;
            idx_q   <= idx_d;
            txm_q   <= txm_d;
        end
    end

    always_comb begin
        state_d = state_q;
        scr_d   = scr_q;
        idx_d   = idx_q;
        txm_d   = txm_q;
        unique case (state_q)
            ST_HOLD: begin
                if (hold_end) state_d = ST_LAUNCH;
            end
            ST_LAUNCH: begin
                if (ser_ready_i) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (ser_done_i) begin
                    if (step.pause_us != '0) begin
                        state_d = ST_PAUSE;
                    end else if (step.last) begin
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_LAUNCH;
                        idx_d   = idx_q + 1'b1;
                    end
                end
            end
            ST_PAUSE: begin
                if (pause_end) begin
                    if (step.last) begin
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_LAUNCH;
                        idx_d   = idx_q + 1'b1;
                    end
                end
            end
            ST_IDLE: begin
                if (ptt_i != txm_q) begin
                    state_d = ST_LAUNCH;
                    txm_d   = ptt_i;
                    scr_d   = ptt_i ? SCR_TX : SCR_RX;
                    idx_d   = '0;
                end
            end
            default: state_d = ST_HOLD;
        endcase
    end

    always_comb begin
        frm_start_o = (state_q == ST_LAUNCH) && ser_ready_i;
        park_o      = (state_q == ST_HOLD);
        tick_clr    = !((state_q == ST_HOLD) || (state_q == ST_PAUSE));
    end
endmodule

// File: rtl/uhf_synth_sequencer_chk.sv
module uhf_synth_sequencer_chk #(
    parameter int FRAME_W = 19
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ser_ready_i,
    input logic               ser_done_i,
    input logic               frm_start_o,
    input logic [FRAME_W-1:0] frm_data_o,
    input logic [4:0]         frm_len_o,
    input logic               park_o
);
    // R10
    start_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_start_o |-> ser_ready_i);

    // R10
    start_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_start_o |=> !frm_start_o);

    // R1
    park_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        park_o |-> !frm_start_o);

    // R1
    park_never_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !park_o |=> !park_o);

    // R3
    ref_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_start_o && frm_len_o == 5'd17) |-> (frm_data_o[2:0] == 3'b111));

    // R4
    freq_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_start_o && frm_len_o == 5'(FRAME_W)) |-> (frm_data_o[2:0] == 3'b001));

    // R6
    frame_len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_start_o |-> (frm_len_o == 5'd17 || frm_len_o == 5'd18 || frm_len_o == 5'(FRAME_W)));
endmodule

bind uhf_synth_sequencer uhf_synth_sequencer_chk #(.FRAME_W(FRAME_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_ready_i (ser_ready_i),
    .ser_done_i  (ser_done_i),
    .frm_start_o (frm_start_o),
    .frm_data_o  (frm_data_o),
    .frm_len_o   (frm_len_o),
    .park_o      (park_o)
);

// File: tb/test_uhf_synth_sequencer.sv
module test_uhf_synth_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int CPU        = 4;
    localparam int HOLD       = 20;
    localparam int SER_LAT    = 5;
    localparam int NFR        = 29;
    localparam int G100       = 100 * CPU + 1;

    typedef struct packed {
        logic [18:0] d;
        logic [4:0]  n;
        logic [15:0] g;
    } exp_t;

    localparam exp_t EXP [NFR] = '{
        '{19'h099A7, 5'd17, 16'(50*CPU+1)},
        '{19'h099A7, 5'd17, 16'(300*CPU+1)},
        '{19'h2E805, 5'd18, 16'(G100)},
        '{19'h469A9, 5'd19, 16'(800*CPU+1)},
        '{19'h2E805, 5'd18, 16'(G100)},
        '{19'h469A9, 5'd19, 16'd0},
        '{19'h2E005, 5'd18, 16'(G100)},
        '{19'h48469, 5'd19, 16'(G100)},
        '{19'h2E205, 5'd18, 16'(G100)},
        '{19'h2E205, 5'd18, 16'd0},
        '{19'h2E805, 5'd18, 16'(G100)},
        '{19'h7FFF9, 5'd19, 16'd0},
        '{19'h2E005, 5'd18, 16'(G100)},
        '{19'h00001, 5'd19, 16'(G100)},
        '{19'h2E205, 5'd18, 16'(G100)},
        '{19'h2E205, 5'd18, 16'(G100+1)},
        '{19'h2E805, 5'd18, 16'(G100)},
        '{19'h7FFF9, 5'd19, 16'd0},
        '{19'h2E005, 5'd18, 16'(G100)},
        '{19'h00001, 5'd19, 16'(G100)},
        '{19'h2E205, 5'd18, 16'(G100)},
        '{19'h2E205, 5'd18, 16'd0},
        '{19'h2E805, 5'd18, 16'd0},
        '{19'h099A7, 5'd17, 16'(50*CPU+1)},
        '{19'h099A7, 5'd17, 16'(300*CPU+1)},
        '{19'h2E805, 5'd18, 16'(G100)},
        '{19'h7FFF9, 5'd19, 16'(800*CPU+1)},
        '{19'h2E805, 5'd18, 16'(G100)},
        '{19'h7FFF9, 5'd19, 16'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ptt = 1'b0;
    logic [15:0] tx_half = 16'd37005;
    logic [15:0] rx_half = 16'd36149;
    logic        ser_ready;
    logic        ser_done = 1'b0;
    logic        frm_start;
    logic [18:0] frm_data;
    logic [4:0]  frm_len;
    logic        park;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int fc     = 0;
    int dc     = 0;
    int hold_cnt = 0;
    bit first_seen = 1'b0;
    int          st  [64];
    int          dn  [64];
    logic [18:0] dat [64];
    logic [4:0]  len [64];

    logic busy = 1'b0;
    int   lat  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uhf_synth_sequencer #(
        .CYC_PER_US(CPU), .HOLD_US(HOLD)
    ) i_uhf_synth_sequencer (
        .clk         (clk),
        .rst_n       (rst_n),
        .ptt_i       (ptt),
        .tx_half_i   (tx_half),
        .rx_half_i   (rx_half),
        .ser_ready_i (ser_ready),
        .ser_done_i  (ser_done),
        .frm_start_o (frm_start),
        .frm_data_o  (frm_data),
        .frm_len_o   (frm_len),
        .park_o      (park)
    );

    assign ser_ready = !busy;

    // serializer model: done pulse SER_LAT cycles after accepting a start
    always @(posedge clk) begin
        cyc <= cyc + 1;
        ser_done <= 1'b0;
        if (!busy) begin
            if (frm_start) begin
                busy <= 1'b1;
                lat  <= SER_LAT;
            end
        end else if (lat == 1) begin
            ser_done <= 1'b1;
            busy     <= 1'b0;
        end else begin
            lat <= lat - 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && park && !first_seen) hold_cnt = hold_cnt + 1;
        if (rst_n && frm_start && fc < 64) begin
            first_seen = 1'b1;
            st[fc]  = cyc;
            dat[fc] = frm_data;
            len[fc] = frm_len;
            fc = fc + 1;
        end
        if (ser_done && dc < 64) begin
            dn[dc] = cyc;
            dc = dc + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_frames(input int n);
        while (fc < n) @(negedge clk);
    endtask

    function automatic string tag_of(input int i);
        if (i >= 23)                                   return "R11";
        if (i < 6)                                     return "R2";
        if (i == 10 || i == 11 || i == 16 || i == 17 || i == 22) return "R6";
        return "R5";
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1 reset park", int'(park), 1);
        check("R1 reset start", int'(frm_start), 0);
        @(posedge clk);
        #1 rst_n = 1'b1;

        wait_frames(6);
        repeat (200) @(negedge clk);
        check("R1 hold cycles", hold_cnt, HOLD * CPU);
        ptt = 1'b1;

        wait_frames(10);
        repeat (1000) @(negedge clk);
        rx_half = 16'd65535;
        ptt = 1'b0;

        wait_frames(12);
        repeat (200) @(negedge clk);
        tx_half = 16'd0;
        ptt = 1'b1;
        wait_frames(13);
        ptt = 1'b0;   // R7: release mid-script
        wait_frames(18);
        repeat (200) @(negedge clk);

        ptt = 1'b1;
        wait_frames(19);
        ptt = 1'b0;   // R8: brief excursion back to receive level
        repeat (3) @(negedge clk);
        ptt = 1'b1;
        wait_frames(22);
        repeat (2000) @(negedge clk);
        check("R8 no extra frame", fc, 22);
        check("R8 parked stays low", int'(park), 0);

        ptt = 1'b0;
        wait_frames(23);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 park after reset", int'(park), 1);
        @(posedge clk);
        #1 rst_n = 1'b1;
        wait_frames(NFR);
        repeat (100) @(negedge clk);

        check("R10 frame count", fc, NFR);
        check("R10 start/done pairs", dc, fc);
        for (int i = 0; i < NFR; i++) begin
            if (EXP[i].n == 5'd17)
                check("R3 ref frame", int'(dat[i]), int'(EXP[i].d));
            else if (EXP[i].n == 5'd19)
                check("R4 freq frame", int'(dat[i]), int'(EXP[i].d));
            else
                check(tag_of(i), int'(dat[i]), int'(EXP[i].d));
            check(tag_of(i), int'(len[i]), int'(EXP[i].n));
            if (EXP[i].g != 16'd0) begin
                if (i == 15)
                    check("R7 script boundary gap", st[i+1] - dn[i], int'(EXP[i].g));
                else
                    check("R9 pause gap", st[i+1] - dn[i], int'(EXP[i].g));
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule